// File: doc/BRIEF.md
# Postfix Expression Stack Evaluator

This block evaluates an unsigned integer arithmetic expression written in postfix order. A producer streams tokens over a valid/ready handshake, one token per accepted transfer, scanning the expression from left to right. A value token is placed on an internal operand stack. An operator token combines the two uppermost entries into one. A closing token reports the single remaining entry as the result, with a one-cycle strobe, and empties the stack for the next expression.

Data is 16 bits wide and wraps modulo 2^16. The stack holds 16 entries. Sum, difference, product and truncating quotient finish in the cycle that accepts the token. Integer power runs over several cycles with a square-and-multiply loop, and input ready stays low until it finishes. Four sticky error flags report the faults: too few entries for an operator, a value pushed onto a full stack, a zero divisor, and a stack that does not hold exactly one entry at the closing token.

A two-state controller sequences the block. In `ST_READY` it accepts tokens. The transition `GO_POWER`, taken when a power operator is accepted with at least two entries present, moves it to `ST_POWER`. In `ST_POWER` input ready is low while the power loop iterates. The transition `POWER_DONE`, taken when the loop reports completion, writes the result back and returns to `ST_READY`.

Top module: `pfx_eval`

## Requirements
- R1: A token with `tok_is_op` = 0 is a value. It is pushed on top of the stack with no other effect, so the stream `7`, close yields 7.
- R2: An operator uses the entry below the top as its left operand and the top entry as its right operand. It replaces both with the single result, so depth drops by one: 6 5 subtract gives 1 and 8 2 divide gives 4.
- R3: Operator codes on `tok_code` with `tok_is_op` = 1 are: 0 add, 1 subtract, 2 multiply, 3 divide, 4 power. Every result wraps modulo 2^16, and divide truncates toward zero.
- R4: Power raises the left operand to the right operand, modulo 2^16, and any value to the power zero gives 1. While the power is being computed, `tok_ready` is low.
- R5: Codes 5, 6 and 7 close the expression. In the next cycle `res_valid` is high for one cycle and `res_value` holds the top entry, or 0 if the stack is empty. The stack is then empty.
- R6: A close with a stack depth other than one sets the sticky flag `err_final`.
- R7: An operator that arrives with fewer than two entries sets the sticky flag `err_underflow` and leaves the stack unchanged.
- R8: A value that arrives while 16 entries are held sets the sticky flag `err_overflow` and is not pushed.
- R9: Divide with a zero right operand sets the sticky flag `err_divzero` and pushes 0 as the result.
- R10: A synchronous reset empties the stack, clears all four flags and `res_valid`, and leaves `tok_ready` high.
- R11: The streams `6 2 3 + - 3 8 2 / + * 2 ^ 3 +`, `2 1 + 3 * 8 4 - - 2 1 + ^` and `4 8 1 2 2 ^ * / -` evaluate to 52, 125 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tok_valid | input | 1 | A token is offered |
| tok_ready | output | 1 | The block accepts a token in this cycle |
| tok_is_op | input | 1 | 1 = operator or close, 0 = value |
| tok_code | input | 3 | Operator or close code |
| tok_value | input | 16 | Value carried by a value token |
| res_valid | output | 1 | One-cycle strobe of a result |
| res_value | output | 16 | Result of the last closed expression |
| err_underflow | output | 1 | Sticky: operator met fewer than two entries |
| err_overflow | output | 1 | Sticky: value pushed onto a full stack |
| err_divzero | output | 1 | Sticky: divide by zero |
| err_final | output | 1 | Sticky: depth was not one at close |

## Verification
A stack pointer that slips, or a wrong write slot, shows up at the very next close. It appears as a wrong `res_value`, or as a spurious or missing `err_final`, so each expression is checked at its close. Swapped operand order shows only on subtract, divide and power, and these operators are exercised with unequal operands. A power loop that stops early, or that loses the ready stall, gives a wrong value at the next close, and it also lets a token in while `tok_ready` should be low. That stall is sampled directly one cycle after the power token is accepted.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    localparam logic [2:0] CODE_ADD = 3'd0;
    localparam logic [2:0] CODE_SUB = 3'd1;
    localparam logic [2:0] CODE_MUL = 3'd2;
    localparam logic [2:0] CODE_DIV = 3'd3;
    localparam logic [2:0] CODE_POW = 3'd4;
    localparam logic [2:0] CODE_END = 3'd5;

    typedef enum logic [1:0] {
        STK_HOLD,
        STK_PUSH,
        STK_REPL,
        STK_CLEAR
    } stk_op_t;

    typedef enum logic {
        ST_READY,
        ST_POWER
    } ctl_state_t;

endpackage

// File: rtl/pfx_stack.sv
module pfx_stack
    import pfx_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH + 1),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  stk_op_t       op,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  top,
    output logic [W-1:0]  below,
    output logic [PW-1:0] depth,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  slots [DEPTH];
    logic [PW-1:0] cnt;
    logic [AW-1:0] i_push;
    logic [AW-1:0] i_top;
    logic [AW-1:0] i_below;

    assign i_push  = AW'(cnt);
    assign i_top   = AW'(cnt - PW'(1));
    assign i_below = AW'(cnt - PW'(2));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            unique case (op)
                STK_PUSH:  cnt <= cnt + PW'(1);
                STK_REPL:  cnt <= cnt - PW'(1);
                STK_CLEAR: cnt <= '0;
                default:   cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (op == STK_PUSH) begin
            slots[i_push] <= wdata;
        end else if (op == STK_REPL) begin
            slots[i_below] <= wdata;
        end
    end

    assign top   = slots[i_top];
    assign below = slots[i_below];
    assign depth = cnt;
    assign full  = (cnt == PW'(DEPTH));
    assign empty = (cnt == '0);

    // R8
    push_room_chk: assert property (@(posedge clk) disable iff (rst)
        (op == STK_PUSH) |-> (cnt < PW'(DEPTH)));

    // R7
    repl_room_chk: assert property (@(posedge clk) disable iff (rst)
        (op == STK_REPL) |-> (cnt >= PW'(2)));

endmodule

// File: rtl/pfx_alu.sv
module pfx_alu
    import pfx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [2:0]   code,
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-1:0] res,
    output logic         div_zero
);

    logic [W-1:0] prod;
    logic [W-1:0] quot;

    assign prod     = lhs * rhs;
    assign div_zero = (code == CODE_DIV) && (rhs == '0);
    assign quot     = (rhs == '0) ? '0 : (lhs / rhs);

    always_comb begin
        unique case (code)
            CODE_ADD: res = lhs + rhs;
            CODE_SUB: res = lhs - rhs;
            CODE_MUL: res = prod;
            CODE_DIV: res = quot;
            default:  res = '0;
        endcase
    end

endmodule

// File: rtl/pfx_pow.sv
module pfx_pow #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] base,
    input  logic [W-1:0] expo,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);

    logic [W-1:0] acc;
    logic [W-1:0] sq;
    logic [W-1:0] ex;
    logic [W-1:0] acc_mul;
    logic [W-1:0] sq_mul;

    assign acc_mul = acc * sq;
    assign sq_mul  = sq * sq;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            acc  <= '0;
            sq   <= '0;
            ex   <= '0;
        end else if (start) begin
            busy <= 1'b1;
            acc  <= W'(1);
            sq   <= base;
            ex   <= expo;
        end else if (busy) begin
            if (ex == '0) begin
                busy <= 1'b0;
            end else begin
                if (ex[0]) begin
                    acc <= acc_mul;
                end
                sq <= sq_mul;
                ex <= ex >> 1;
            end
        end
    end

    assign done   = busy && (ex == '0);
    assign result = acc;

endmodule

// File: rtl/pfx_eval.sv
module pfx_eval
    import pfx_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tok_valid,
    output logic         tok_ready,
    input  logic         tok_is_op,
    input  logic [2:0]   tok_code,
    input  logic [W-1:0] tok_value,
    output logic         res_valid,
    output logic [W-1:0] res_value,
    output logic         err_underflow,
    output logic         err_overflow,
    output logic         err_divzero,
    output logic         err_final
);

    ctl_state_t    state;
    ctl_state_t    state_nx;
    stk_op_t       stk_op;
    logic [W-1:0]  stk_wdata;
    logic [W-1:0]  stk_top;
    logic [W-1:0]  stk_below;
    logic [PW-1:0] stk_depth;
    logic          stk_full;
    logic          stk_empty;
    logic [W-1:0]  alu_res;
    logic          alu_dz;
    logic          pow_start;
    logic          pow_busy;
    logic          pow_done;
    logic [W-1:0]  pow_res;
    logic          fire;
    logic          is_end;
    logic          is_arith;
    logic          short_stk;

    pfx_stack #(.W(W), .DEPTH(DEPTH)) u_stack (
        .clk   (clk),
        .rst   (rst),
        .op    (stk_op),
        .wdata (stk_wdata),
        .top   (stk_top),
        .below (stk_below),
        .depth (stk_depth),
        .full  (stk_full),
        .empty (stk_empty)
    );

    pfx_alu #(.W(W)) u_alu (
        .code     (tok_code),
        .lhs      (stk_below),
        .rhs      (stk_top),
        .res      (alu_res),
        .div_zero (alu_dz)
    );

    pfx_pow #(.W(W)) u_pow (
        .clk    (clk),
        .rst    (rst),
        .start  (pow_start),
        .base   (stk_below),
        .expo   (stk_top),
        .busy   (pow_busy),
        .done   (pow_done),
        .result (pow_res)
    );

    assign tok_ready = (state == ST_READY);
    assign fire      = tok_valid && tok_ready;
    assign is_end    = tok_is_op && (tok_code >= CODE_END);
    assign is_arith  = tok_is_op && !is_end;
    assign short_stk = (stk_depth < PW'(2));

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_READY;
        end else begin
            state <= state_nx;
        end
    end

    // next state and stack control
    always_comb begin
        state_nx  = state;
        stk_op    = STK_HOLD;
        stk_wdata = tok_value;
        pow_start = 1'b0;
        unique case (state)
            ST_READY: begin
                if (fire) begin
                    if (!tok_is_op) begin
                        if (!stk_full) begin
                            stk_op = STK_PUSH;
                        end
                    end else if (is_end) begin
                        stk_op = STK_CLEAR;
                    end else if (!short_stk) begin
                        if (tok_code == CODE_POW) begin
                            pow_start = 1'b1;
                            state_nx  = ST_POWER;
                        end else begin
                            stk_op    = STK_REPL;
                            stk_wdata = alu_res;
                        end
                    end
                end
            end
            ST_POWER: begin
                if (pow_done) begin
                    stk_op    = STK_REPL;
                    stk_wdata = pow_res;
                    state_nx  = ST_READY;
                end
            end
            default: state_nx = ST_READY;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid     <= 1'b0;
            res_value     <= '0;
            err_underflow <= 1'b0;
            err_overflow  <= 1'b0;
            err_divzero   <= 1'b0;
            err_final     <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            if (fire) begin
                if (!tok_is_op && stk_full) begin
                    err_overflow <= 1'b1;
                end
                if (is_arith && short_stk) begin
                    err_underflow <= 1'b1;
                end
                if (is_arith && !short_stk && alu_dz) begin
                    err_divzero <= 1'b1;
                end
                if (is_end) begin
                    res_valid <= 1'b1;
                    res_value <= stk_empty ? '0 : stk_top;
                    if (stk_depth != PW'(1)) begin
                        err_final <= 1'b1;
                    end
                end
            end
        end
    end

    // R8
    ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !tok_is_op && stk_full) |=> (err_overflow && $stable(stk_depth)));

    // R7
    udf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && is_arith && short_stk) |=> (err_underflow && $stable(stk_depth)));

    // R5
    end_clear_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (stk_depth == '0));

    // R4
    pow_stall_chk: assert property (@(posedge clk) disable iff (rst)
        pow_busy |-> !tok_ready);

    // R9
    dz_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && tok_is_op && tok_code == CODE_DIV && !short_stk && stk_top == '0)
            |=> err_divzero);

endmodule

// File: tb/pfx_eval_tb.sv
`timescale 1ns/1ps
module pfx_eval_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tok_valid = 1'b0;
    logic        tok_ready;
    logic        tok_is_op = 1'b0;
    logic [2:0]  tok_code = 3'd0;
    logic [15:0] tok_value = 16'd0;
    logic        res_valid;
    logic [15:0] res_value;
    logic        err_underflow;
    logic        err_overflow;
    logic        err_divzero;
    logic        err_final;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #4 clk = ~clk;

    pfx_eval u_dut (
        .clk           (clk),
        .rst           (rst),
        .tok_valid     (tok_valid),
        .tok_ready     (tok_ready),
        .tok_is_op     (tok_is_op),
        .tok_code      (tok_code),
        .tok_value     (tok_value),
        .res_valid     (res_valid),
        .res_value     (res_value),
        .err_underflow (err_underflow),
        .err_overflow  (err_overflow),
        .err_divzero   (err_divzero),
        .err_final     (err_final)
    );

    // reference model
    logic [15:0] ms [16];
    int          md;
    logic [15:0] m_res;
    bit          m_udf, m_ovf, m_dz, m_fin;

    function automatic logic [15:0] ref_pow(logic [15:0] b, logic [15:0] e);
        logic [15:0] r = 16'd1;
        for (int i = 0; i < int'(e); i++) r = r * b;
        return r;
    endfunction

    function automatic logic [15:0] ref_op(int code, logic [15:0] a, logic [15:0] b);
        case (code)
            0: return a + b;
            1: return a - b;
            2: return a * b;
            3: return (b == 16'd0) ? 16'd0 : a / b;
            default: return ref_pow(a, b);
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        md = 0; m_udf = 0; m_ovf = 0; m_dz = 0; m_fin = 0; m_res = 0;
    endtask

    task automatic model_apply(bit isop, int code, logic [15:0] v);
        if (!isop) begin
            if (md == 16) m_ovf = 1;
            else begin ms[md] = v; md++; end
        end else if (code >= 5) begin
            m_res = (md == 0) ? 16'd0 : ms[md-1];
            if (md != 1) m_fin = 1;
            md = 0;
        end else if (md < 2) begin
            m_udf = 1;
        end else begin
            if (code == 3 && ms[md-1] == 16'd0) m_dz = 1;
            ms[md-2] = ref_op(code, ms[md-2], ms[md-1]);
            md--;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        tok_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    task automatic send(bit isop, int code, logic [15:0] v);
        @(negedge clk);
        tok_valid = 1'b1;
        tok_is_op = isop;
        tok_code  = 3'(code);
        tok_value = v;
        while (!tok_ready) @(negedge clk);
        @(negedge clk);
        tok_valid = 1'b0;
        model_apply(isop, code, v);
    endtask

    task automatic val(logic [15:0] v);
        send(1'b0, 0, v);
    endtask

    task automatic opr(int code);
        send(1'b1, code, 16'd0);
    endtask

    task automatic close_check(string req, int code = 5);
        send(1'b1, code, 16'd0);
        check({req, " res_valid"}, res_valid, 1);
        check({req, " res_value"}, res_value, m_res);
        check({req, " err_underflow"}, err_underflow, m_udf);
        check({req, " err_overflow"}, err_overflow, m_ovf);
        check({req, " err_divzero"}, err_divzero, m_dz);
        check({req, " err_final"}, err_final, m_fin);
        @(negedge clk);
        check({req, " R5 strobe one cycle"}, res_valid, 0);
    endtask

    // token codes: 0 add 1 sub 2 mul 3 div 4 pow
    initial begin
        void'($urandom(32'd20240611));
        model_clear();
        do_reset();

        // R10 reset state
        check("R10 tok_ready", tok_ready, 1);
        check("R10 res_valid", res_valid, 0);
        check("R10 flags", {err_underflow, err_overflow, err_divzero, err_final}, 0);

        // R1 single value
        val(7); close_check("R1");
        check("R1 value", res_value, 7);

        // R11 worked streams
        val(6); val(2); val(3); opr(0); opr(1); val(3); val(8); val(2); opr(3);
        opr(0); opr(2); val(2); opr(4); val(3); opr(0); close_check("R11 a");
        check("R11 a=52", res_value, 52);
        val(2); val(1); opr(0); val(3); opr(2); val(8); val(4); opr(1); opr(1);
        val(2); val(1); opr(0); opr(4); close_check("R11 b", 7);
        check("R11 b=125", res_value, 125);
        val(4); val(8); val(1); val(2); val(2); opr(4); opr(2); opr(3); opr(1);
        close_check("R11 c", 6);
        check("R11 c=2", res_value, 2);

        // R2 operand order
        val(6); val(5); opr(1); close_check("R2 sub");
        check("R2 6-5", res_value, 1);
        val(8); val(2); opr(3); close_check("R2 div");
        check("R2 8/2", res_value, 4);

        // R3 wrap and truncation
        val(16'hFFFF); val(1); opr(0); close_check("R3 add wrap");
        val(3); val(5); opr(1); close_check("R3 sub wrap");
        val(300); val(300); opr(2); close_check("R3 mul wrap");
        val(7); val(2); opr(3); close_check("R3 div trunc");

        // R4 power stall and zero exponent
        val(3); val(16); opr(4);
        check("R4 ready low during power", tok_ready, 0);
        close_check("R4 3^16");
        val(5); val(0); opr(4); close_check("R4 5^0");
        check("R4 5^0=1", res_value, 1);
        val(0); val(0); opr(4); close_check("R4 0^0");

        // R5 R6 close on empty stack
        close_check("R6 empty");
        check("R5 empty gives 0", res_value, 0);
        check("R6 err_final empty", err_final, 1);
        do_reset();
        val(4); val(5); close_check("R6 two left");
        check("R6 err_final two", err_final, 1);
        do_reset();

        // R7 underflow leaves stack unchanged
        val(5); opr(0); close_check("R7");
        check("R7 flag", err_underflow, 1);
        check("R7 value kept", res_value, 5);
        do_reset();

        // R9 divide by zero
        val(9); val(0); opr(3); close_check("R9");
        check("R9 flag", err_divzero, 1);
        check("R9 pushes 0", res_value, 0);
        do_reset();

        // R8 overflow: seventeenth value dropped
        for (int i = 1; i <= 17; i++) val(16'(i));
        close_check("R8");
        check("R8 flag", err_overflow, 1);
        check("R8 top is 16", res_value, 16);
        do_reset();

        // R3 R9 random expressions against the model
        for (int e = 0; e < 60; e++) begin
            int n = 1 + int'($urandom % 8);
            int pushed = 0;
            int d = 0;
            while (pushed < n || d > 1) begin
                if (pushed < n && (d < 2 || ($urandom % 2) == 0)) begin
                    logic [15:0] v;
                    v = (($urandom % 3) == 0) ? 16'($urandom % 4) : 16'($urandom);
                    val(v);
                    pushed++; d++;
                end else begin
                    opr(int'($urandom % 5));
                    d--;
                end
            end
            close_check("R3 R9 random", 5 + int'($urandom % 3));
        end

        ended = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule